// File: doc/BRIEF.md
# Additive Latency Command Delay

This block sits between the command decoder of a DDR3-style memory device and its internal column logic. A READ or WRITE column command, with or without auto-precharge, may be issued on the cycle right after ACTIVATE. The block holds each such command for the programmed additive latency (AL) and then releases it, with its type, auto-precharge flag and column address, to the internal array logic. Commands may arrive on every cycle, and they leave in the order they came in.

The block also works out the read latency (AL plus CAS latency) and the write latency (AL plus CAS write latency). It raises a one-cycle data-start strobe that many cycles after each external READ or WRITE. AL is not programmed directly. A 2-bit mode code selects zero, CL-1 or CL-2. A configuration update is accepted only when nothing is in flight. An update that is rejected leaves every setting unchanged and pulses an error flag.

Top module: `al_cmd_delay`

## Requirements
- R1: After reset all outputs are low and the settings are AL=0, CL=5, CWL=5.
- R2: An update with mode code 2'b11 (reserved) is rejected. `cfg_err` is high for one cycle in the following cycle, and AL, CL and CWL keep their previous values.
- R3: With AL>0, a command accepted in cycle t appears on `int_valid`, `int_is_wr`, `int_ap` and `int_addr` in cycle t+AL. Mode code 2'b01 gives AL=CL-1 and code 2'b10 gives AL=CL-2. Back-to-back commands leave one per cycle in arrival order.
- R4: With AL=0 (code 2'b00), the command fields appear on the internal outputs in the same cycle, with no register stage.
- R5: `rd_data_start` is high exactly in cycle t+AL+CL for each READ (`cmd_is_wr`=0) accepted in cycle t.
- R6: `wr_data_start` is high exactly in cycle t+AL+CWL for each WRITE (`cmd_is_wr`=1) accepted in cycle t.
- R7: An update is rejected, with `cfg_err` pulsed in the next cycle, in any of these cases: a command is presented in the same cycle, a command is waiting in the delay line, or a data-start strobe is still pending, up to and including the cycle in which it fires.
- R8: An update with CL outside 5..14 or CWL outside 5..10 is rejected, with `cfg_err` pulsed in the next cycle.
- R9: An accepted update takes effect from the next cycle, and `cfg_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A column command is presented this cycle |
| cmd_is_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_ap | input | 1 | Auto-precharge requested |
| cmd_addr | input | 14 | Column address |
| cfg_wr | input | 1 | Update strobe for the latency settings |
| cfg_al_code | input | 2 | Additive latency mode code |
| cfg_cl | input | 4 | CAS latency value |
| cfg_cwl | input | 4 | CAS write latency value |
| int_valid | output | 1 | Delayed command released to the array |
| int_is_wr | output | 1 | Type of the released command |
| int_ap | output | 1 | Auto-precharge flag of the released command |
| int_addr | output | 14 | Address of the released command |
| rd_data_start | output | 1 | Read data phase starts this cycle |
| wr_data_start | output | 1 | Write data phase starts this cycle |
| cfg_err | output | 1 | Previous-cycle update was rejected |

## Verification
The hardest case to reach is an update that lands in the last cycle of a pending data strobe, or while one long-latency write strobe is still outstanding after its command has already left the delay line. The bench reaches it by mixing random command bursts with random update attempts across the largest settings (AL up to 13, RL up to 27). Its queue-based model then decides from its own pending-event list whether each update is accepted, and compares all outputs on every cycle.

// File: rtl/al_pkg.sv
package al_pkg;
  localparam int LAT_W = 6;
  typedef logic [LAT_W-1:0] lat_t;

  // Mode code to additive latency: 00 -> 0, 01 -> CL-1, 10 -> CL-2.
  function automatic lat_t al_from_code(input logic [1:0] code, input lat_t cl);
    case (code)
      2'b01:   return cl - lat_t'(1);
      2'b10:   return cl - lat_t'(2);
      default: return '0;
    endcase
  endfunction

  function automatic lat_t lat_sum(input lat_t a, input lat_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/al_cfg_reg.sv
module al_cfg_reg
  import al_pkg::*;
#(
  parameter int CL_IN_W = 4,
  parameter int MIN_CL  = 5,
  parameter int MAX_CL  = 14,
  parameter int MIN_CWL = 5,
  parameter int MAX_CWL = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         code,
  input  logic [CL_IN_W-1:0] cl_in,
  input  logic [CL_IN_W-1:0] cwl_in,
  input  logic               busy,
  output lat_t               al_q,
  output lat_t               cl_q,
  output lat_t               cwl_q,
  output logic               err_q
);
  logic code_ok, cl_ok, cwl_ok, accept;

  assign code_ok = (code != 2'b11);
  assign cl_ok   = (cl_in >= CL_IN_W'(MIN_CL)) && (cl_in <= CL_IN_W'(MAX_CL));
  assign cwl_ok  = (cwl_in >= CL_IN_W'(MIN_CWL)) && (cwl_in <= CL_IN_W'(MAX_CWL));
  assign accept  = cfg_wr && code_ok && cl_ok && cwl_ok && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q  <= '0;
      cl_q  <= lat_t'(MIN_CL);
      cwl_q <= lat_t'(MIN_CWL);
      err_q <= 1'b0;
    end else begin
      err_q <= cfg_wr && !accept;
      if (accept) begin
        al_q  <= al_from_code(code, lat_t'(cl_in));
        cl_q  <= lat_t'(cl_in);
        cwl_q <= lat_t'(cwl_in);
      end
    end
  end

  // R2: reserved code keeps settings and flags an error
  p_rsv_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && code == 2'b11) |=> (err_q && $stable(al_q) && $stable(cl_q) && $stable(cwl_q)));

  // R7: update while in flight is refused
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy) |=> (err_q && $stable(al_q) && $stable(cl_q) && $stable(cwl_q)));

  // R8: out-of-range latency is refused
  p_range_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cl_in < CL_IN_W'(MIN_CL) || cwl_in > CL_IN_W'(MAX_CWL))) |=> err_q);
endmodule

// File: rtl/al_delay_line.sv
module al_delay_line
  import al_pkg::*;
#(
  parameter int DEPTH = 13,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lat_t         tap,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] v_q, v_d;
  logic [W-1:0]     d_q [DEPTH];
  logic [W-1:0]     d_d [DEPTH];
  logic [IDX_W-1:0] sel;

  // A stage holds an entry only while it lies before the output tap,
  // so an entry already delivered can never reach a later tap.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         src_v;
    logic [W-1:0] src_d;
    if (i == 0) begin : g_head
      assign src_v = in_valid;
      assign src_d = in_data;
    end else begin : g_link
      assign src_v = v_q[i-1];
      assign src_d = d_q[i-1];
    end
    assign v_d[i] = src_v && (lat_t'(i) < tap);
    assign d_d[i] = src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < DEPTH; k++) d_q[k] <= '0;
    end else begin
      v_q <= v_d;
      d_q <= d_d;
    end
  end

  assign sel       = IDX_W'(tap - lat_t'(1));
  assign out_valid = (tap == '0) ? in_valid : v_q[sel];
  assign out_data  = (tap == '0) ? in_data  : d_q[sel];
  assign busy      = |v_q;

  // R8: the configuration block never hands over a tap past the end
  p_tap_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tap <= lat_t'(DEPTH));
endmodule

// File: rtl/al_cmd_delay.sv
module al_cmd_delay
  import al_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int CL_IN_W = 4,
  parameter int MIN_CL  = 5,
  parameter int MAX_CL  = 14,
  parameter int MIN_CWL = 5,
  parameter int MAX_CWL = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_is_wr,
  input  logic               cmd_ap,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_al_code,
  input  logic [CL_IN_W-1:0] cfg_cl,
  input  logic [CL_IN_W-1:0] cfg_cwl,
  output logic               int_valid,
  output logic               int_is_wr,
  output logic               int_ap,
  output logic [ADDR_W-1:0]  int_addr,
  output logic               rd_data_start,
  output logic               wr_data_start,
  output logic               cfg_err
);
  localparam int MAX_AL   = MAX_CL - 1;
  localparam int RD_DEPTH = MAX_AL + MAX_CL;
  localparam int WR_DEPTH = MAX_AL + MAX_CWL;
  localparam int CMD_W    = ADDR_W + 2;

  lat_t al_q, cl_q, cwl_q, rl, wl;
  logic cmd_busy, rd_busy, wr_busy, busy_any;
  logic rd_v, rd_d, wr_v, wr_d;
  logic [CMD_W-1:0] cmd_out;

  assign rl = lat_sum(al_q, cl_q);
  assign wl = lat_sum(al_q, cwl_q);
  assign busy_any = cmd_valid || cmd_busy || rd_busy || wr_busy;

  al_cfg_reg #(
    .CL_IN_W(CL_IN_W), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL),
    .MIN_CWL(MIN_CWL), .MAX_CWL(MAX_CWL)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .code(cfg_al_code),
    .cl_in(cfg_cl), .cwl_in(cfg_cwl), .busy(busy_any),
    .al_q(al_q), .cl_q(cl_q), .cwl_q(cwl_q), .err_q(cfg_err)
  );

  al_delay_line #(.DEPTH(MAX_AL), .W(CMD_W)) i_cmd_line (
    .clk(clk), .rst_n(rst_n), .tap(al_q), .in_valid(cmd_valid),
    .in_data({cmd_is_wr, cmd_ap, cmd_addr}),
    .out_valid(int_valid), .out_data(cmd_out), .busy(cmd_busy)
  );

  al_delay_line #(.DEPTH(RD_DEPTH), .W(1)) i_rd_line (
    .clk(clk), .rst_n(rst_n), .tap(rl), .in_valid(cmd_valid && !cmd_is_wr),
    .in_data(1'b1), .out_valid(rd_v), .out_data(rd_d), .busy(rd_busy)
  );

  al_delay_line #(.DEPTH(WR_DEPTH), .W(1)) i_wr_line (
    .clk(clk), .rst_n(rst_n), .tap(wl), .in_valid(cmd_valid && cmd_is_wr),
    .in_data(1'b1), .out_valid(wr_v), .out_data(wr_d), .busy(wr_busy)
  );

  assign {int_is_wr, int_ap, int_addr} = cmd_out;
  assign rd_data_start = rd_v && rd_d;
  assign wr_data_start = wr_v && wr_d;

  // R3: nothing leaves when nothing is stored and nothing arrives
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid || cmd_busy || rd_busy || wr_busy) |-> !(int_valid || rd_data_start || wr_data_start));

  // R5: a read strobe only fires while the read line holds an entry
  p_rd_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_start |-> rd_busy);

  // R6: a write strobe only fires while the write line holds an entry
  p_wr_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_start |-> wr_busy);
endmodule

// File: tb/test_al_cmd_delay.sv
module test_al_cmd_delay;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_is_wr = 0, cmd_ap = 0;
  logic [13:0] cmd_addr = '0;
  logic cfg_wr = 0;
  logic [1:0] cfg_al_code = '0;
  logic [3:0] cfg_cl = 4'd5, cfg_cwl = 4'd5;
  logic int_valid, int_is_wr, int_ap, rd_data_start, wr_data_start, cfg_err;
  logic [13:0] int_addr;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; bit wr; bit ap; logic [13:0] addr; } ev_t;
  ev_t cmdq[$];
  int rdq[$];
  int wrq[$];
  int al_m = 0, cl_m = 5, cwl_m = 5;
  bit err_pend = 0;

  always #(PERIOD/2) clk = ~clk;

  al_cmd_delay i_al_cmd_delay (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_ap(cmd_ap), .cmd_addr(cmd_addr), .cfg_wr(cfg_wr), .cfg_al_code(cfg_al_code),
    .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .int_valid(int_valid), .int_is_wr(int_is_wr),
    .int_ap(int_ap), .int_addr(int_addr), .rd_data_start(rd_data_start),
    .wr_data_start(wr_data_start), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit wr, input bit ap, input logic [13:0] a,
                      input bit cw, input logic [1:0] code, input int cl, input int cwl);
    bit busy, ev, er, ew;
    ev_t e;
    @(negedge clk);
    cmd_valid = v; cmd_is_wr = wr; cmd_ap = ap; cmd_addr = a;
    cfg_wr = cw; cfg_al_code = code; cfg_cl = 4'(cl); cfg_cwl = 4'(cwl);
    #1;
    busy = v || cmdq.size() > 0 || rdq.size() > 0 || wrq.size() > 0;
    if (v) begin
      cmdq.push_back('{due: cyc + al_m, wr: wr, ap: ap, addr: a});
      if (wr) wrq.push_back(cyc + al_m + cwl_m);
      else    rdq.push_back(cyc + al_m + cl_m);
    end
    ev = 0; e = '{due: 0, wr: 0, ap: 0, addr: '0};
    foreach (cmdq[k]) if (cmdq[k].due == cyc) begin ev = 1; e = cmdq[k]; end
    er = 0; foreach (rdq[k]) if (rdq[k] == cyc) er = 1;
    ew = 0; foreach (wrq[k]) if (wrq[k] == cyc) ew = 1;
    // R3 / R4: delayed command release (R4 when AL is 0)
    chk(int_valid == ev, (al_m == 0) ? "R4 int_valid" : "R3 int_valid", int_valid, ev);
    if (ev && int_valid) begin
      chk(int_is_wr == e.wr, "R3 int_is_wr", int_is_wr, e.wr);
      chk(int_ap == e.ap, "R3 int_ap", int_ap, e.ap);
      chk(int_addr == e.addr, "R3 int_addr", int_addr, e.addr);
    end
    chk(rd_data_start == er, "R5 rd_data_start", rd_data_start, er);
    chk(wr_data_start == ew, "R6 wr_data_start", wr_data_start, ew);
    chk(cfg_err == err_pend, "R2/R7/R8/R9 cfg_err", cfg_err, err_pend);
    if (cw) begin
      if (code == 2'b11 || busy || cl < 5 || cl > 14 || cwl < 5 || cwl > 10) err_pend = 1;
      else begin
        err_pend = 0;
        al_m = (code == 2'b01) ? cl - 1 : (code == 2'b10) ? cl - 2 : 0;
        cl_m = cl; cwl_m = cwl;
      end
    end else err_pend = 0;
    cmdq = cmdq.find with (item.due != cyc);
    rdq = rdq.find with (item != cyc);
    wrq = wrq.find with (item != cyc);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, '0, 0, 2'b00, 5, 5);
  endtask

  task automatic cfg(input logic [1:0] code, input int cl, input int cwl);
    step(0, 0, 0, '0, 1, code, cl, cwl);
  endtask

  task automatic burst(input int n, input int seed);
    for (int k = 0; k < n; k++)
      step(1, 1'((k + seed) % 3 == 0), 1'(k[0]), 14'(seed * 97 + k * 13), 0, 2'b00, 5, 5);
  endtask

  task automatic rand_phase(input int n);
    for (int k = 0; k < n; k++) begin
      bit cw = ($urandom_range(0, 15) == 0);
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           14'($urandom), cw, 2'($urandom_range(0, 3)), $urandom_range(4, 15),
           $urandom_range(4, 11));
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state of outputs
    chk(int_valid == 0, "R1 int_valid", int_valid, 0);
    chk(rd_data_start == 0, "R1 rd_data_start", rd_data_start, 0);
    chk(wr_data_start == 0, "R1 wr_data_start", wr_data_start, 0);
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    // R1 / R4: reset settings AL=0 CL=5 CWL=5, same-cycle pass-through
    burst(6, 1); idle(12);
    // R9 / R3: AL=CL-1=5
    cfg(2'b01, 6, 5); burst(8, 2);
    // R7: update while in flight
    cfg(2'b00, 5, 5);
    step(1, 0, 1, 14'h155, 1, 2'b00, 5, 5);
    idle(20);
    // R2: reserved code
    cfg(2'b11, 7, 6); burst(3, 3); idle(20);
    // R8: out-of-range values
    cfg(2'b10, 4, 5); idle(2); cfg(2'b10, 15, 5); idle(2); cfg(2'b01, 8, 11); idle(2);
    // R3: AL=CL-2 at max settings, AL=12 RL=26 WL=22
    cfg(2'b10, 14, 10); burst(10, 4);
    // R7: the last strobe cycle still counts as busy
    for (int k = 0; k < 30; k++) step(0, 0, 0, '0, 1, 2'b01, 14, 10);
    // R3: AL=13 (longest line)
    cfg(2'b01, 14, 10); burst(12, 5); idle(30);
    rand_phase(3000); idle(40);
    cfg(2'b00, 9, 7); rand_phase(2000); idle(40);
    cfg(2'b10, 5, 5); rand_phase(2000); idle(40);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule